// File: doc/BRIEF.md
# Flash Protected-Range Address Checker

This block sits in front of a serial flash command engine and decides whether each flash access may start. It holds five programmable range registers. Each register gives a lower and an upper limit on address bits 24:12, so every range covers whole 4 KB pages. Each register also has one enable for read protection and one for write protection. Write protection covers both program and erase cycles.

When a request strobe arrives, the address is compared against all five ranges at once. If the address falls inside any range whose enable matches the access kind, the access is blocked. The engine must then not start that cycle. A blocked access also sets a sticky error flag, which is cleared by writing 1 to it. A lock-down input freezes every range register until the next reset.

Top module: `flash_range_guard`

## Requirements
- R1: After reset, `acc_grant`, `acc_block`, `err_flag` and `locked` are 0, and every range register reads back as zero.
- R2: A register write to index 0..4 stores the word with the reserved bits 30:29 and 14:13 forced to zero. The field layout is: bit 31 write-protect enable, bits 28:16 upper page, bit 15 read-protect enable, bits 12:0 lower page. A write to index 5..7 changes nothing, and those indices read back as zero.
- R3: A write/erase access (`acc_write`=1) is blocked when its page (address bits 24:12) lies within [lower, upper] of a range that has bit 31 set.
- R4: A read access (`acc_write`=0) is blocked only by ranges that have bit 15 set. A range with only bit 31 set does not block reads, and a range with only bit 15 set does not block writes.
- R5: Both bounds are inclusive at byte level. Address lower*4096 and address upper*4096+4095 are inside the range. Address lower*4096-1 and address (upper+1)*4096 are outside it and are granted.
- R6: A range whose upper page is below its lower page matches no address.
- R7: A match in any one of the five ranges is enough to block an access. This holds for index 4 as well as index 0.
- R8: On the cycle after `acc_req`, exactly one of `acc_grant` and `acc_block` is 1. On the cycle after a cycle without a request, both are 0. The decision uses the register contents from before any register write in the same cycle as the request.
- R9: `err_flag` is set on the same edge that raises `acc_block` and stays set until an `err_clr` pulse. If a block and a clear happen in the same cycle, the flag stays set.
- R10: A `lock_set` pulse sets `locked`. From then on, register writes are ignored until reset, and the existing ranges keep blocking. Reset clears both the lock and the ranges.
- R11: A register write in the same cycle as `lock_set` still takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Range register write strobe |
| reg_wr_idx | input | 3 | Range register index to write |
| reg_wr_data | input | 32 | Range register write word |
| lock_set | input | 1 | Pulse to freeze the range registers until reset |
| rd_idx | input | 3 | Range register index to read back |
| rd_data | output | 32 | Read-back word for `rd_idx` (combinational) |
| locked | output | 1 | Lock-down state |
| acc_req | input | 1 | Flash access request strobe |
| acc_addr | input | 25 | Flash byte address of the access |
| acc_write | input | 1 | 1 = program or erase, 0 = read |
| acc_grant | output | 1 | Access allowed, one cycle after the request |
| acc_block | output | 1 | Access refused, one cycle after the request |
| err_clr | input | 1 | Write-1 clear of the error flag |
| err_flag | output | 1 | Sticky access-error flag |

## Verification
The hardest case to reach from the ports is a request that lands exactly on a page edge of a range, while another cycle's register write or lock pulse is being applied at the same time. Once locked, the ranges cannot be reprogrammed before a reset, so the stimulus works in phases. First it programs ranges with edge-aligned limits and probes each boundary byte. Next it mixes random requests with register writes aimed at a small page window, so that writes and requests often fall in the same cycle. Finally it sends a register write together with the lock pulse, tries a rewrite, and resets. A behavioural reference model is compared against every output on every clock.

// File: rtl/flash_range_guard.sv
module flash_range_guard #(
  parameter int NUM_RANGES = 5,
  parameter int ADDR_W     = 25,
  parameter int IDX_W      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [IDX_W-1:0]  reg_wr_idx,
  input  logic [31:0]       reg_wr_data,
  input  logic              lock_set,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [31:0]       rd_data,
  output logic              locked,
  input  logic              acc_req,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_write,
  output logic              acc_grant,
  output logic              acc_block,
  input  logic              err_clr,
  output logic              err_flag
);

  localparam int PAGE_LSB = 12;
  localparam int LIM_W    = ADDR_W - PAGE_LSB;
  localparam int UP_LSB   = 16;
  localparam int WP_BIT   = 31;
  localparam int RP_BIT   = 15;
  localparam logic [31:0] LIM_ONES = 32'((64'd1 << LIM_W) - 64'd1);
  localparam logic [31:0] KEEP_MASK =
    (32'd1 << WP_BIT) | (LIM_ONES << UP_LSB) | (32'd1 << RP_BIT) | LIM_ONES;

  logic [NUM_RANGES-1:0][31:0] range_q;
  logic [NUM_RANGES-1:0]       hit_vec;
  logic                        locked_q, grant_q, block_q, err_q;
  logic [LIM_W-1:0]            page;
  logic                        hit;

  assign page = acc_addr[ADDR_W-1:PAGE_LSB];

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_range
    logic [LIM_W-1:0] lo, hi;
    logic             en;
    assign lo = range_q[i][LIM_W-1:0];
    assign hi = range_q[i][UP_LSB +: LIM_W];
    assign en = acc_write ? range_q[i][WP_BIT] : range_q[i][RP_BIT];
    assign hit_vec[i] = en && (page >= lo) && (page <= hi);

    always_ff @(posedge clk) begin
      if (!rst_n)
        range_q[i] <= '0;
      else if (reg_wr_en && !locked_q && reg_wr_idx == IDX_W'(i))
        range_q[i] <= reg_wr_data & KEEP_MASK;
    end
  end

  assign hit = |hit_vec;

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_RANGES; i++)
      if (rd_idx == IDX_W'(i)) rd_data = range_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      grant_q  <= 1'b0;
      block_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      locked_q <= locked_q | lock_set;
      grant_q  <= acc_req & ~hit;
      block_q  <= acc_req & hit;
      err_q    <= (err_q & ~err_clr) | (acc_req & hit);
    end
  end

  assign locked    = locked_q;
  assign acc_grant = grant_q;
  assign acc_block = block_q;
  assign err_flag  = err_q;

  p_one_decision_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |=> $onehot({acc_grant, acc_block}));
  p_no_decision_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_req |=> !acc_grant && !acc_block);
  p_block_sets_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_block |-> err_flag);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);
  p_lock_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);
  p_frozen_regs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(range_q));
  p_same_cycle_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !locked && lock_set && reg_wr_en && reg_wr_idx < IDX_W'(NUM_RANGES)
      |=> locked && range_q[$past(reg_wr_idx)] == ($past(reg_wr_data) & KEEP_MASK));

endmodule

// File: tb/flash_range_guard_bench.sv
`timescale 1ns/1ps
module flash_range_guard_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [2:0]  reg_wr_idx = '0;
  logic [31:0] reg_wr_data = '0;
  logic        lock_set = 1'b0;
  logic [2:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        locked;
  logic        acc_req = 1'b0;
  logic [24:0] acc_addr = '0;
  logic        acc_write = 1'b0;
  logic        acc_grant, acc_block;
  logic        err_clr = 1'b0;
  logic        err_flag;

  always #2.5 clk = ~clk;

  flash_range_guard u_flash_range_guard (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_idx(reg_wr_idx), .reg_wr_data(reg_wr_data),
    .lock_set(lock_set), .rd_idx(rd_idx), .rd_data(rd_data), .locked(locked),
    .acc_req(acc_req), .acc_addr(acc_addr), .acc_write(acc_write),
    .acc_grant(acc_grant), .acc_block(acc_block),
    .err_clr(err_clr), .err_flag(err_flag)
  );

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";
  bit    done = 0;

  logic [31:0] m_reg [5];
  logic        m_lock, m_err, m_grant, m_block;

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_hit(logic [24:0] a, logic wr);
    int pg = int'(a >> 12);
    for (int i = 0; i < 5; i++) begin
      bit en = wr ? m_reg[i][31] : m_reg[i][15];
      int lo = int'(m_reg[i][12:0]);
      int hi = int'(m_reg[i][28:16]);
      if (en && pg >= lo && pg <= hi) return 1;
    end
    return 0;
  endfunction

  task automatic compare_all();
    chk("grant", 32'(acc_grant), 32'(m_grant));
    chk("block", 32'(acc_block), 32'(m_block));
    chk("err", 32'(err_flag), 32'(m_err));
    chk("locked", 32'(locked), 32'(m_lock));
    chk("rd_data", rd_data, (rd_idx < 5) ? m_reg[rd_idx] : 32'h0);
  endtask

  task automatic cyc(bit we, int idx, logic [31:0] d, bit lk,
                     bit rq, logic [24:0] a, bit wr, bit clr, int ridx);
    bit h;
    @(negedge clk);
    reg_wr_en = we; reg_wr_idx = 3'(idx); reg_wr_data = d; lock_set = lk;
    acc_req = rq; acc_addr = a; acc_write = wr; err_clr = clr; rd_idx = 3'(ridx);
    @(posedge clk);
    h = model_hit(a, wr);
    m_grant = rq && !h;
    m_block = rq && h;
    m_err = (m_err && !clr) || (rq && h);
    if (we && !m_lock && idx < 5) m_reg[idx] = d & 32'h9FFF9FFF;
    m_lock = m_lock || lk;
    #1;
    compare_all();
  endtask

  task automatic acc(logic [24:0] a, bit wr, bit exp_blk);
    cyc(0, 0, 0, 0, 1, a, wr, 0, 0);
    chk("literal block", 32'(acc_block), 32'(exp_blk));
  endtask

  task automatic wr_reg(int idx, logic [31:0] d);
    cyc(1, idx, d, 0, 0, 0, 0, 0, idx);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; reg_wr_en = 0; lock_set = 0; acc_req = 0; err_clr = 0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 5; i++) m_reg[i] = '0;
    m_lock = 0; m_err = 0; m_grant = 0; m_block = 0;
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, i);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    do_reset();

    tag = "R2";
    wr_reg(0, 32'hE012_6010);
    chk("readback", rd_data, 32'h8012_0010);
    cyc(1, 5, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 5);
    chk("idx5 read", rd_data, 32'h0);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("idx0 unchanged", rd_data, 32'h8012_0010);

    tag = "R3"; acc(25'h0010000, 1, 1); acc(25'h0011800, 1, 1);
    tag = "R5"; acc(25'h000FFFF, 1, 0); acc(25'h0012FFF, 1, 1); acc(25'h0013000, 1, 0);
    tag = "R4"; acc(25'h0011000, 0, 0);
    wr_reg(1, 32'h0100_8100);
    acc(25'h0100800, 0, 1); acc(25'h0100800, 1, 0);

    tag = "R6";
    wr_reg(2, 32'h81FF_8200);
    acc(25'h01FF800, 1, 0); acc(25'h0200000, 0, 0);

    tag = "R7";
    wr_reg(4, 32'h9FFF_1FFF);
    acc(25'h1FFFFFF, 1, 1); acc(25'h1FFEFFF, 1, 0);

    tag = "R8";
    cyc(0, 0, 0, 0, 0, 25'h0010000, 1, 0, 0);
    chk("idle grant", 32'(acc_grant), 0);
    chk("idle block", 32'(acc_block), 0);
    cyc(1, 0, 32'h0, 0, 1, 25'h0010000, 1, 0, 0);
    chk("old regs used", 32'(acc_block), 1);
    wr_reg(0, 32'hE012_6010);

    tag = "R9";
    chk("err set", 32'(err_flag), 1);
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("err cleared", 32'(err_flag), 0);
    cyc(0, 0, 0, 0, 1, 25'h0010000, 1, 1, 0);
    chk("set beats clear", 32'(err_flag), 1);

    tag = "R8";
    for (int n = 0; n < 2000; n++) begin
      bit we = ($urandom % 4) == 0;
      logic [31:0] d = $urandom & 32'h8FFF_8FFF;
      logic [24:0] a = 25'({$urandom % 32, 12'($urandom)});
      if (($urandom % 8) == 0) a[24:12] = 13'h1FFF;
      cyc(we, int'($urandom % 8), d & 32'h801F_801F, 0, $urandom % 2, a,
          $urandom % 2, ($urandom % 5) == 0, int'($urandom % 8));
    end

    tag = "R11";
    do_reset();
    wr_reg(0, 32'h8012_0010);
    cyc(1, 3, 32'h8040_8040, 1, 0, 0, 0, 0, 3);
    chk("same-cycle write", rd_data, 32'h8040_8040);
    chk("locked", 32'(locked), 1);

    tag = "R10";
    cyc(1, 0, 32'h0, 0, 0, 0, 0, 0, 0);
    chk("frozen", rd_data, 32'h8012_0010);
    acc(25'h0010000, 1, 1);
    acc(25'h0040000, 0, 1);
    do_reset();
    chk("lock cleared", 32'(locked), 0);
    wr_reg(0, 32'h8001_0001);
    chk("writable", rd_data, 32'h8001_0001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule